// File: doc/BRIEF.md
# Serial Block-Transfer I/O Channel

This channel moves 12-bit words between processor memory and an external peripheral over a bit-serial link. Once started, it runs without the processor. For each word it takes one memory cycle through a request/grant port. In the memory-to-peripheral direction it reads a word into a holding buffer. In the peripheral-to-memory direction it writes the holding buffer back. All serial shifting is done in a separate shift register.

The processor programs a start address, a word count and a direction through a small register window, then issues a start command. The peripheral can also start the transfer by raising its request line. The peripheral supplies the bit clock, so it sets the serial rate. Its frame strobe marks the first bit of each word. The peripheral clock, frame, data and request lines are brought into the system clock domain through a multi-flop synchroniser. A level interrupt is raised only when the whole sequence has ended, either normally or through an overrun.

Top module: `sbt_channel`

## Requirements
- R1: The register window is selected by `cfg_sel`: 0 = address, 1 = word count, 2 = control, 3 = status. In the control register, bit 0 is the direction (0 = memory to peripheral, 1 = peripheral to memory) and bit 1 is a self-clearing start. Writing control with bit 1 set while idle, with a nonzero count, makes the channel busy (status bit 2).
- R2: A rising edge on `per_req` while idle starts a transfer with the programmed address, count and direction.
- R3: In the memory-to-peripheral direction, words are read from consecutive addresses and presented on `per_sdo` most-significant bit first. Each bit is valid at a rising edge of `per_clk`. Consecutive words need no idle clocks between them.
- R4: In the peripheral-to-memory direction, `per_sdi` is sampled on rising edges of `per_clk`, most-significant bit first. Each completed 12-bit word is written to consecutive addresses.
- R5: `mem_req` stays asserted, with stable address, write flag and write data, until `mem_gnt` is seen. Exactly one word moves per grant.
- R6: The address register advances by one per word moved and the count register decreases by one per word shifted. After a complete block of N words the address reads start+N and the count reads 0.
- R7: A count of 1 moves exactly one word with exactly one memory access.
- R8: `irq` and status bit 0 rise only when the sequence ends and stay high until the status register is written. Status reads 0 after reset.
- R9: An overrun ends the block and sets sticky status bit 1 together with the interrupt. In the memory-to-peripheral direction, an overrun is a clock edge with no word loaded for shifting. In the peripheral-to-memory direction, it is a word completing while the previous one is still unstored.
- R10: While busy, writes to the address, count and control registers, start commands and `per_req` edges have no effect. A start with a count of 0 is ignored.
- R11: A frame strobe sampled with a bit makes that bit the first bit of a word, discarding any partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 12 | Register write data |
| cfg_rdata | output | 12 | Register read data for `cfg_sel` |
| mem_req | output | 1 | Cycle-steal request |
| mem_we | output | 1 | Request is a write to memory |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Word written to memory |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | 12 | Read data, valid with the grant |
| irq | output | 1 | End-of-sequence interrupt, level |
| per_clk | input | 1 | Peripheral-driven bit clock |
| per_frame | input | 1 | First-bit marker, sampled with the bit |
| per_sdi | input | 1 | Serial data from the peripheral |
| per_req | input | 1 | Peripheral start request |
| per_sdo | output | 1 | Serial data to the peripheral |

## Verification
Embedded properties check on every cycle the following behaviours:
- an unanswered memory request holds its address and data until it is granted;
- each granted word advances the address by exactly one;
- the interrupt rises only as the busy state ends, and falls only after a status write;
- an overrun never appears without the interrupt;
- the bit counter stays in range and frames realign it.

Only bench scenarios can show the rest:
- the bit order and gap-free streaming of outgoing words;
- the addresses and data of incoming words;
- that register writes and requests made while busy change nothing;
- the two overrun cases, which need memory grants to be withheld.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

   typedef enum logic [1:0] {
      REG_ADDR  = 2'd0,
      REG_COUNT = 2'd1,
      REG_CTRL  = 2'd2,
      REG_STAT  = 2'd3
   } reg_sel_e;

   typedef enum logic {
      DIR_TO_PER = 1'b0,
      DIR_TO_MEM = 1'b1
   } dir_e;

   localparam int CTRL_DIR_BIT = 0;
   localparam int CTRL_GO_BIT  = 1;
   localparam int STAT_IRQ_BIT = 0;
   localparam int STAT_OVR_BIT = 1;
   localparam int STAT_BSY_BIT = 2;

endpackage

// File: rtl/sbt_sync.sv
module sbt_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sbt_sync needs at least two stages");
   end
   if (W < 1) begin : g_bad_width
      $error("sbt_sync width must be positive");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sbt_shifter.sv
module sbt_shifter #(
   parameter int WORD_W      = 12,
   parameter bit SAMPLE_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              clk_s,
   input  logic              frame_s,
   input  logic              sdi_s,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   output logic              bit_edge,
   output logic              word_done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sdo
);
   localparam int CW = $clog2(WORD_W + 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("sbt_shifter word must be at least two bits");
   end

   logic              clk_last;
   logic              edge_raw;
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     nxt;
   logic [WORD_W-1:0] sh;

   if (SAMPLE_RISE) begin : g_rise
      assign edge_raw = clk_s & ~clk_last;
   end else begin : g_fall
      assign edge_raw = ~clk_s & clk_last;
   end

   assign bit_edge  = en & edge_raw;
   assign nxt       = frame_s ? CW'(1) : cnt + 1'b1;
   assign word_done = bit_edge && (nxt == CW'(WORD_W));
   assign rx_word   = {sh[WORD_W-2:0], sdi_s};
   assign sdo       = sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_last <= 1'b0;
         cnt      <= '0;
         sh       <= '0;
      end else begin
         clk_last <= clk_s;
         if (clr)           cnt <= '0;
         else if (bit_edge) cnt <= word_done ? '0 : nxt;
         if (load)          sh  <= load_word;
         else if (bit_edge) sh  <= rx_word;
      end
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(WORD_W));

   // R11
   frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_edge && frame_s && !clr) |=> (cnt == CW'(1)));
endmodule

// File: rtl/sbt_seq.sv
module sbt_seq
   import sbt_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int ADDR_W = 12,
   parameter int CNT_W  = 12,
   parameter int REG_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              req_s,
   input  logic              bit_edge,
   input  logic              word_done,
   input  logic [WORD_W-1:0] rx_word,
   output logic              load,
   output logic [WORD_W-1:0] load_word,
   output logic              sh_clr,
   output logic              shift_en,
   output logic              tx_drive,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              irq
);
   if (REG_W < 3 || REG_W < ADDR_W || REG_W < CNT_W) begin : g_bad_reg
      $error("sbt_seq register width too small");
   end

   reg_sel_e          sel;
   dir_e              dir;
   logic              busy, ovr, irq_q, req_last;
   logic [ADDR_W-1:0] addr;
   logic [CNT_W-1:0]  xfer_left, fetch_left;
   logic [WORD_W-1:0] buf_q;
   logic              buf_full, sh_valid;
   logic              is_tx, req_rise, wr_ctrl, go_cmd, start_go, fire;
   logic              tx_under, rx_over, rx_take, tx_step, tx_last, rx_last, finish;
   logic              stat_clr;

   assign sel      = reg_sel_e'(cfg_sel);
   assign is_tx    = (dir == DIR_TO_PER);
   assign req_rise = req_s & ~req_last;
   assign wr_ctrl  = cfg_we && (sel == REG_CTRL);
   assign go_cmd   = wr_ctrl && cfg_wdata[CTRL_GO_BIT];
   assign stat_clr = cfg_we && (sel == REG_STAT);
   assign start_go = !busy && (go_cmd || req_rise) && (xfer_left != '0);

   assign mem_req  = busy && (is_tx ? (!buf_full && fetch_left != '0) : buf_full);
   assign mem_we   = !is_tx;
   assign mem_addr = addr;
   assign mem_wdata = buf_q;
   assign fire     = mem_req && mem_gnt;

   assign load     = busy && is_tx && buf_full && !sh_valid;
   assign load_word = buf_q;
   assign tx_under = busy && is_tx && bit_edge && !sh_valid;
   assign tx_step  = busy && is_tx && word_done && sh_valid;
   assign tx_last  = tx_step && (xfer_left == CNT_W'(1));
   assign rx_over  = busy && !is_tx && word_done && buf_full && !fire;
   assign rx_take  = busy && !is_tx && word_done && !rx_over;
   assign rx_last  = busy && !is_tx && (xfer_left == '0) && !buf_full;
   assign finish   = tx_last || rx_last || tx_under || rx_over;

   assign sh_clr   = start_go;
   assign shift_en = busy;
   assign tx_drive = busy && is_tx && sh_valid;
   assign irq      = irq_q;

   always_comb begin
      unique case (sel)
         REG_ADDR:  cfg_rdata = REG_W'(addr);
         REG_COUNT: cfg_rdata = REG_W'(xfer_left);
         REG_CTRL:  cfg_rdata = REG_W'(dir);
         default:   cfg_rdata = REG_W'({busy, ovr, irq_q});
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir        <= DIR_TO_PER;
         busy       <= 1'b0;
         ovr        <= 1'b0;
         irq_q      <= 1'b0;
         req_last   <= 1'b0;
         addr       <= '0;
         xfer_left  <= '0;
         fetch_left <= '0;
         buf_q      <= '0;
         buf_full   <= 1'b0;
         sh_valid   <= 1'b0;
      end else begin
         req_last <= req_s;
         if (stat_clr) begin
            irq_q <= 1'b0;
            ovr   <= 1'b0;
         end
         if (!busy) begin
            if (cfg_we && sel == REG_ADDR)  addr      <= ADDR_W'(cfg_wdata);
            if (cfg_we && sel == REG_COUNT) xfer_left <= CNT_W'(cfg_wdata);
            if (wr_ctrl) dir <= dir_e'(cfg_wdata[CTRL_DIR_BIT]);
            if (start_go) begin
               busy       <= 1'b1;
               fetch_left <= xfer_left;
               buf_full   <= 1'b0;
               sh_valid   <= 1'b0;
            end
         end else begin
            if (fire) begin
               addr <= addr + 1'b1;
               if (is_tx) begin
                  buf_q      <= mem_rdata;
                  buf_full   <= 1'b1;
                  fetch_left <= fetch_left - 1'b1;
               end else begin
                  buf_full <= 1'b0;
               end
            end
            if (load) begin
               sh_valid <= 1'b1;
               buf_full <= 1'b0;
            end
            if (tx_step) begin
               xfer_left <= xfer_left - 1'b1;
               sh_valid  <= 1'b0;
            end
            if (rx_take) begin
               buf_q     <= rx_word;
               buf_full  <= 1'b1;
               xfer_left <= xfer_left - 1'b1;
            end
            if (finish) begin
               busy     <= 1'b0;
               irq_q    <= 1'b1;
               buf_full <= 1'b0;
               sh_valid <= 1'b0;
               if (tx_under || rx_over) ovr <= 1'b1;
            end
         end
      end
   end

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (!busy || (mem_req && $stable(mem_addr)
                                && $stable(mem_we) && $stable(mem_wdata))));

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (mem_addr == $past(mem_addr) + 1'b1));

   // R6
   fetch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_tx) |-> (fetch_left <= xfer_left));

   // R8
   irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $fell(busy));

   // R8
   irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(cfg_we && cfg_sel == 2'd3));

   // R9
   ovr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> irq);
endmodule

// File: rtl/sbt_channel.sv
module sbt_channel
   import sbt_pkg::*;
#(
   parameter int  WORD_W      = 12,
   parameter int  ADDR_W      = 12,
   parameter int  CNT_W       = 12,
   parameter int  SYNC_STAGES = 2,
   parameter bit  SAMPLE_RISE = 1'b1,
   localparam int REG_W       = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              irq,
   input  logic              per_clk,
   input  logic              per_frame,
   input  logic              per_sdi,
   input  logic              per_req,
   output logic              per_sdo
);
   logic [3:0]        raw_in, sync_out;
   logic              clk_s, frame_s, sdi_s, req_s;
   logic              bit_edge, word_done, load, sh_clr, shift_en, tx_drive, sdo_raw;
   logic [WORD_W-1:0] rx_word, load_word;

   assign raw_in = {per_req, per_clk, per_frame, per_sdi};
   assign {req_s, clk_s, frame_s, sdi_s} = sync_out;

   sbt_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   sbt_shifter #(.WORD_W(WORD_W), .SAMPLE_RISE(SAMPLE_RISE)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(shift_en), .clr(sh_clr),
      .clk_s(clk_s), .frame_s(frame_s), .sdi_s(sdi_s),
      .load(load), .load_word(load_word),
      .bit_edge(bit_edge), .word_done(word_done), .rx_word(rx_word), .sdo(sdo_raw)
   );

   sbt_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_s(req_s), .bit_edge(bit_edge), .word_done(word_done), .rx_word(rx_word),
      .load(load), .load_word(load_word), .sh_clr(sh_clr), .shift_en(shift_en),
      .tx_drive(tx_drive),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
   );

   assign per_sdo = tx_drive & sdo_raw;

   // R3
   sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |-> !per_sdo);
endmodule

// File: tb/sbt_channel_tb.sv
`timescale 1ns/1ps
module sbt_channel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [11:0] cfg_wdata = '0;
   logic [11:0] cfg_rdata;
   logic        mem_req, mem_we;
   logic [11:0] mem_addr, mem_wdata;
   logic        mem_gnt = 1'b0;
   logic [11:0] mem_rdata = '0;
   logic        irq;
   logic        per_clk = 1'b0, per_frame = 1'b0, per_sdi = 1'b0, per_req = 1'b0;
   logic        per_sdo;

   int total = 0, bad = 0;
   int tx_q[$];
   int rx_q[$];
   logic [11:0] mem [0:255];
   int gnt_lat = 1, wait_cnt = 0, rd_count = 0, wr_count = 0;
   bit stall = 1'b0, mon_on = 1'b0;
   int mbits = 0;
   logic [11:0] mword = '0;

   always #10 clk = ~clk;

   sbt_channel u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq),
      .per_clk(per_clk), .per_frame(per_frame), .per_sdi(per_sdi),
      .per_req(per_req), .per_sdo(per_sdo)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: grants after gnt_lat waiting cycles, one-cycle grant pulses
   always @(negedge clk) begin
      if (mem_gnt) mem_gnt = 1'b0;
      else if (rst_n && mem_req && !stall) begin
         if (wait_cnt >= gnt_lat) begin
            mem_gnt  = 1'b1;
            wait_cnt = 0;
            if (mem_we) begin
               wr_count++;
               if (rx_q.size() == 0) chk("R4 unexpected write", {mem_addr, mem_wdata}, -1);
               else chk("R4 stored word", {mem_addr, mem_wdata}, rx_q.pop_front());
               mem[mem_addr[7:0]] = mem_wdata;
            end else begin
               rd_count++;
               mem_rdata = mem[mem_addr[7:0]];
            end
         end else wait_cnt++;
      end else wait_cnt = 0;
   end

   // serial monitor for memory-to-peripheral words
   always @(posedge per_clk) begin
      if (mon_on) begin
         mword = {mword[10:0], per_sdo};
         mbits = per_frame ? 1 : mbits + 1;
         if (mbits == 12) begin
            mbits = 0;
            if (tx_q.size() == 0) chk("R3 unexpected word", mword, -1);
            else chk("R3 serial word", mword, tx_q.pop_front());
         end
      end
   end

   task automatic cfg_wr(input logic [1:0] s, input logic [11:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic [1:0] s, output int v);
      @(negedge clk); cfg_sel = s; #1 v = cfg_rdata;
   endtask

   task automatic bit_out(input logic fr, input logic d);
      @(negedge clk); per_frame = fr; per_sdi = d; per_clk = 1'b0;
      repeat (3) @(negedge clk);
      per_clk = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_word(input logic [11:0] w);
      for (int i = 11; i >= 0; i--) bit_out(i == 11, w[i]);
   endtask

   task automatic clock_words(input int n);
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 12; i++) bit_out(i == 0, 1'b0);
   endtask

   task automatic expect_tx(input int base, input int n);
      for (int k = 0; k < n; k++) tx_q.push_back(mem[(base + k) & 255]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v, r0;
      for (int i = 0; i < 256; i++) mem[i] = 12'((i * 37 + 5) ^ (i << 4));
      mem[8'h10] = 12'h9C3; mem[8'h11] = 12'h0F1; mem[8'h12] = 12'hFFE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      cfg_rd(2'd3, v); chk("R8 reset status", v, 0);
      chk("R8 reset irq", irq, 0);
      chk("R5 reset mem_req", mem_req, 0);
      chk("R3 reset sdo", per_sdo, 0);

      // R1 R3 R6: three-word block to peripheral, slow grants
      gnt_lat = 5;
      cfg_wr(2'd0, 12'h010); cfg_wr(2'd1, 12'd3); cfg_wr(2'd2, 12'h002);
      cfg_rd(2'd3, v); chk("R1 busy after start", v, 4);
      expect_tx(16, 3); mon_on = 1'b1;
      repeat (20) @(negedge clk);
      for (int k = 0; k < 35; k++) bit_out((k % 12) == 0, 1'b0);
      chk("R8 no irq before last bit", irq, 0);
      bit_out(1'b0, 1'b0);
      repeat (3) @(negedge clk);
      chk("R8 irq at end", irq, 1);
      cfg_rd(2'd3, v); chk("R8 status done", v, 1);
      cfg_rd(2'd0, v); chk("R6 address after block", v, 12'h013);
      cfg_rd(2'd1, v); chk("R6 count after block", v, 0);
      chk("R3 words consumed", tx_q.size(), 0);
      repeat (5) @(negedge clk);
      chk("R8 irq held", irq, 1);
      cfg_wr(2'd3, 12'h000);
      chk("R8 irq cleared", irq, 0);
      gnt_lat = 1;

      // R7 single word
      r0 = rd_count;
      cfg_wr(2'd0, 12'h020); cfg_wr(2'd1, 12'd1); cfg_wr(2'd2, 12'h002);
      expect_tx(32, 1);
      repeat (10) @(negedge clk);
      clock_words(1);
      repeat (3) @(negedge clk);
      chk("R7 single read", rd_count - r0, 1);
      cfg_rd(2'd3, v); chk("R7 single done", v, 1);
      cfg_rd(2'd0, v); chk("R7 address", v, 12'h021);
      cfg_wr(2'd3, 12'h000);
      mon_on = 1'b0;

      // R2 R4: four words from peripheral, started by request
      cfg_wr(2'd0, 12'h040); cfg_wr(2'd1, 12'd4); cfg_wr(2'd2, 12'h001);
      cfg_rd(2'd3, v); chk("R2 idle before request", v, 0);
      @(negedge clk); per_req = 1'b1;
      repeat (6) @(negedge clk);
      cfg_rd(2'd3, v); chk("R2 busy after request", v, 4);
      for (int k = 0; k < 4; k++) begin
         logic [11:0] w;
         w = 12'(12'hA51 + k * 12'h3C7);
         rx_q.push_back({12'(12'h040 + k), w});
         send_word(w);
      end
      repeat (6) @(negedge clk);
      per_req = 1'b0;
      cfg_rd(2'd3, v); chk("R4 done status", v, 1);
      cfg_rd(2'd0, v); chk("R6 rx address", v, 12'h044);
      cfg_rd(2'd1, v); chk("R6 rx count", v, 0);
      chk("R4 writes consumed", rx_q.size(), 0);
      cfg_wr(2'd3, 12'h000);

      // R10 zero-count start ignored
      cfg_wr(2'd1, 12'd0); cfg_wr(2'd2, 12'h002);
      repeat (4) @(negedge clk);
      cfg_rd(2'd3, v); chk("R10 zero count start", v, 0);
      chk("R10 no request", mem_req, 0);

      // R10 writes and starts while busy
      cfg_wr(2'd0, 12'h060); cfg_wr(2'd1, 12'd2); cfg_wr(2'd2, 12'h003);
      cfg_wr(2'd0, 12'h099); cfg_rd(2'd0, v); chk("R10 address write ignored", v, 12'h060);
      cfg_wr(2'd1, 12'd7);   cfg_rd(2'd1, v); chk("R10 count write ignored", v, 2);
      cfg_wr(2'd2, 12'h002); cfg_rd(2'd2, v); chk("R10 control write ignored", v, 1);
      @(negedge clk); per_req = 1'b1; repeat (5) @(negedge clk); per_req = 1'b0;
      rx_q.push_back({12'h060, 12'h123}); send_word(12'h123);
      rx_q.push_back({12'h061, 12'hFED}); send_word(12'hFED);
      repeat (6) @(negedge clk);
      cfg_rd(2'd3, v); chk("R10 block ends normally", v, 1);
      cfg_rd(2'd0, v); chk("R10 address", v, 12'h062);
      cfg_wr(2'd3, 12'h000);

      // R11 frame realigns after junk bits
      cfg_wr(2'd0, 12'h070); cfg_wr(2'd1, 12'd1); cfg_wr(2'd2, 12'h003);
      bit_out(1'b1, 1'b1);
      for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b1);
      rx_q.push_back({12'h070, 12'hA5C}); send_word(12'hA5C);
      repeat (6) @(negedge clk);
      chk("R11 realigned word stored", rx_q.size(), 0);
      cfg_rd(2'd3, v); chk("R11 done", v, 1);
      cfg_wr(2'd3, 12'h000);

      // R9 output overrun: no grant before first edge
      stall = 1'b1;
      cfg_wr(2'd0, 12'h030); cfg_wr(2'd1, 12'd2); cfg_wr(2'd2, 12'h002);
      repeat (4) @(negedge clk);
      bit_out(1'b1, 1'b0);
      repeat (2) @(negedge clk);
      cfg_rd(2'd3, v); chk("R9 output overrun status", v, 3);
      chk("R9 output overrun irq", irq, 1);
      chk("R9 request dropped", mem_req, 0);
      cfg_wr(2'd3, 12'h000);
      cfg_rd(2'd3, v); chk("R9 overrun cleared", v, 0);

      // R9 input overrun: second word completes before first is stored
      r0 = wr_count;
      cfg_wr(2'd0, 12'h080); cfg_wr(2'd1, 12'd3); cfg_wr(2'd2, 12'h003);
      send_word(12'h111); send_word(12'h222);
      repeat (4) @(negedge clk);
      cfg_rd(2'd3, v); chk("R9 input overrun status", v, 3);
      chk("R9 no write during stall", wr_count - r0, 0);
      chk("R9 request dropped after end", mem_req, 0);
      stall = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 still no write", wr_count - r0, 0);
      cfg_wr(2'd3, 12'h000);
      chk("R8 final irq clear", irq, 0);

      chk("R3 queue empty", tx_q.size(), 0);
      chk("R4 queue empty", rx_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule